// File: doc/BRIEF.md
# Serial Controller Host Register Bank with Interrupt Logic

This block is the byte-wide register interface that a host uses to program and service a serial controller. A 3-bit offset, together with separate read and write strobes, selects the baud divisor, the interrupt enable mask, the interrupt identification, the line control, the modem control, the line status and the modem status registers. The block holds the transmit holding byte and the receive buffer byte. It keeps the sticky receive error flags and the modem change flags. It ranks the pending interrupt causes and drives a single interrupt request.

Offsets 0 and 1 have two meanings. While the top bit of the line control register is set, they reach the two divisor bytes. Otherwise offset 0 carries characters and offset 1 holds the enable mask. The transmitter takes characters through a valid/take pair and reports when it is idle. The receiver delivers each completed character with a one-cycle strobe and its error flags. The four modem input pins are sampled on every clock, and each change leaves a flag that stays set until the host reads modem status. The interrupt request reaches the host only while modem control output 2 is set.

Top module: `uart_regbank`

## Requirements
- R1: After reset, interrupt enable, line control and modem control read 0x00. Line status reads 0x60 while tx_idle is 1. Interrupt ID reads 0x01, and irq is 0.
- R2: With line control bit 7 set, offset 0 reads and writes divisor bits 7:0 and offset 1 reads and writes divisor bits 15:8. With bit 7 clear, offset 1 is the interrupt enable register. Its bits 3:0 are stored, its bits 7:4 read 0, and the divisor does not change.
- R3: Line control reads back as written and drives word_len from bits 1:0, two_stop from bit 2, parity_en from bit 3, parity_even from bit 4, parity_stick from bit 5 and send_break from bit 6.
- R4: Modem control bits 0 to 4 drive dtr, rts, out1, out2 and loop_en. Bits 7:5 read 0.
- R5: A write to offset 0 with line control bit 7 clear puts the byte on tx_data, raises tx_valid and clears line status bit 5. A tx_take pulse sets bit 5 again. Line status bit 6 follows tx_idle, and bit 7 reads 0.
- R6: An rx_valid pulse loads rx_data into the receive buffer and sets line status bit 0. A read of offset 0 with line control bit 7 clear returns the byte and clears bit 0. An rx_valid pulse that arrives while bit 0 is set sets bit 1 (overrun).
- R7: Line status bits 2, 3 and 4 are set by rx_parity_err, rx_frame_err and rx_break when rx_valid is high. A read of line status clears bits 1 to 4.
- R8: Modem status bits 7:4 show rlsd, ri, dsr and cts. Bits 0 to 3 set when cts, dsr, ri or rlsd respectively changes, and a read of modem status clears them.
- R9: Interrupt ID bit 0 is 0 only when an enabled cause is pending, and bits 2:1 name the highest cause. The ranking, from highest, is 11 for enabled line errors (enable bit 2), 10 for received data (enable bit 0), 01 for transmit empty (enable bit 1) and 00 for a modem change (enable bit 3). Bits 7:3 read 0.
- R10: A transmit-empty cause becomes pending when line status bit 5 rises while enable bit 1 is set, or when enable bit 1 is written from 0 to 1 while bit 5 is set. It is removed by a transmit write, by clearing enable bit 1, or by a read of interrupt ID that reports it.
- R11: irq is 1 exactly when out2 is 1 and some cause is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | 3 | Register offset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe (triggers read side effects) |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for the current offset |
| tx_data | output | 8 | Transmit holding byte |
| tx_valid | output | 1 | Transmit holding byte waiting |
| tx_take | input | 1 | Transmitter took the holding byte |
| tx_idle | input | 1 | Transmit shifter empty |
| rx_valid | input | 1 | Received character strobe |
| rx_data | input | 8 | Received character |
| rx_parity_err | input | 1 | Parity error with the character |
| rx_frame_err | input | 1 | Framing error with the character |
| rx_break | input | 1 | Break seen with the character |
| cts | input | 1 | Clear to send pin |
| dsr | input | 1 | Data set ready pin |
| ri | input | 1 | Ring indicator pin |
| rlsd | input | 1 | Carrier detect pin |
| dtr | output | 1 | Data terminal ready |
| rts | output | 1 | Request to send |
| out1 | output | 1 | General output 1 |
| out2 | output | 1 | General output 2, gates irq |
| loop_en | output | 1 | Loopback enable |
| divisor | output | 16 | Baud divisor |
| word_len | output | 2 | Data bits code |
| two_stop | output | 1 | Extra stop bit select |
| parity_en | output | 1 | Parity enable |
| parity_even | output | 1 | Even parity select |
| parity_stick | output | 1 | Stick parity select |
| send_break | output | 1 | Force line to space |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume that the modem pins are already synchronous to clk. They also assume that wr_en and rd_en are never high together, and that tx_take arrives only while tx_valid is high. The stimulus holds to these limits. Every access is one strobe driven on the falling edge. Pin changes are applied alone and are given a cycle to settle before modem status is read. tx_take is pulsed only after a transmit write. The random phase mixes received characters with random error flags, buffer and status reads, pin flips and transmit write/take pairs. A bench model predicts line status, modem status, interrupt ID and irq.

// File: rtl/uart_rb_pkg.sv
package uart_rb_pkg;
   localparam int unsigned OFS_DATA = 0;
   localparam int unsigned OFS_IEN  = 1;
   localparam int unsigned OFS_IID  = 2;
   localparam int unsigned OFS_LCTL = 3;
   localparam int unsigned OFS_MCTL = 4;
   localparam int unsigned OFS_LSTS = 5;
   localparam int unsigned OFS_MSTS = 6;

   typedef enum logic [1:0] {
      CAUSE_MODEM = 2'b00,
      CAUSE_TXMT  = 2'b01,
      CAUSE_RXDAT = 2'b10,
      CAUSE_LINE  = 2'b11
   } cause_e;
endpackage

// File: rtl/rb_modem_delta.sv
module rb_modem_delta #(
   parameter int unsigned N_PINS        = 4,
   parameter int unsigned RI_IDX        = 2,
   parameter bit          RI_TRAIL_ONLY = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [N_PINS-1:0] pins,
   input  logic              rd_clr,
   output logic [N_PINS-1:0] delta
);
   logic [N_PINS-1:0] prev_q;
   logic [N_PINS-1:0] chg;
   logic              armed_q;

   generate
      for (genvar i = 0; i < N_PINS; i++) begin : g_bit
         if (RI_TRAIL_ONLY && (i == RI_IDX)) begin : g_trail
            assign chg[i] = prev_q[i] & ~pins[i];
         end else begin : g_any
            assign chg[i] = prev_q[i] ^ pins[i];
         end
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         prev_q  <= '0;
         armed_q <= 1'b0;
         delta   <= '0;
      end else begin
         prev_q  <= pins;
         armed_q <= 1'b1;
         for (int i = 0; i < N_PINS; i++) begin
            if (armed_q && chg[i]) delta[i] <= 1'b1;
            else if (rd_clr)       delta[i] <= 1'b0;
         end
      end
   end

   // R8
   delta_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_clr && armed_q && (pins == prev_q)) |=> (delta == '0));
endmodule

// File: rtl/rb_line_status.sv
module rb_line_status #(
   parameter int unsigned BYTE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rx_valid,
   input  logic [BYTE_W-1:0] rx_data,
   input  logic              rx_pe,
   input  logic              rx_fe,
   input  logic              rx_bi,
   input  logic              rbr_rd,
   input  logic              lsr_rd,
   input  logic              thr_wr,
   input  logic              tx_take,
   input  logic              tx_idle,
   output logic [BYTE_W-1:0] rbr,
   output logic [BYTE_W-1:0] lsr,
   output logic              dr,
   output logic              err_any,
   output logic              thre,
   output logic              thre_rise
);
   logic oe_q, pe_q, fe_q, bi_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rbr  <= '0;
         dr   <= 1'b0;
         oe_q <= 1'b0;
         pe_q <= 1'b0;
         fe_q <= 1'b0;
         bi_q <= 1'b0;
         thre <= 1'b1;
      end else begin
         if (rx_valid) rbr <= rx_data;

         if (rx_valid)    dr <= 1'b1;
         else if (rbr_rd) dr <= 1'b0;

         if (rx_valid && dr)         oe_q <= 1'b1;
         else if (lsr_rd)            oe_q <= 1'b0;
         if (rx_valid && rx_pe)      pe_q <= 1'b1;
         else if (lsr_rd)            pe_q <= 1'b0;
         if (rx_valid && rx_fe)      fe_q <= 1'b1;
         else if (lsr_rd)            fe_q <= 1'b0;
         if (rx_valid && rx_bi)      bi_q <= 1'b1;
         else if (lsr_rd)            bi_q <= 1'b0;

         if (thr_wr)       thre <= 1'b0;
         else if (tx_take) thre <= 1'b1;
      end
   end

   assign thre_rise = tx_take & ~thre & ~thr_wr;
   assign err_any   = oe_q | pe_q | fe_q | bi_q;

   always_comb begin
      lsr    = '0;
      lsr[0] = dr;
      lsr[1] = oe_q;
      lsr[2] = pe_q;
      lsr[3] = fe_q;
      lsr[4] = bi_q;
      lsr[5] = thre;
      lsr[6] = tx_idle;
   end

   // R6
   overrun_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_valid && dr) |=> oe_q);

   // R5
   thre_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      thr_wr |=> !thre);

   // R7
   err_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (lsr_rd && !rx_valid) |=> !err_any);
endmodule

// File: rtl/rb_irq_ctrl.sv
module rb_irq_ctrl
   import uart_rb_pkg::*;
#(
   parameter int unsigned BYTE_W        = 8,
   parameter int unsigned N_CAUSE       = 4,
   parameter bit          ARM_ON_ENABLE = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [N_CAUSE-1:0] ien,
   input  logic               ien_wr,
   input  logic               ien_wbit,
   input  logic               err_any,
   input  logic               dr,
   input  logic               thre,
   input  logic               thre_rise,
   input  logic               thr_wr,
   input  logic               iid_rd,
   input  logic               msr_any,
   output logic [BYTE_W-1:0]  iid,
   output logic               pend_any
);
   logic   tx_pend_q;
   logic   arm_en;
   cause_e cause;

   generate
      if (ARM_ON_ENABLE) begin : g_arm
         assign arm_en = ien_wr & ien_wbit & ~ien[1] & thre;
      end else begin : g_noarm
         assign arm_en = 1'b0;
      end
   endgenerate

   always_comb begin
      pend_any = 1'b1;
      cause    = CAUSE_MODEM;
      if (ien[2] && err_any)        cause = CAUSE_LINE;
      else if (ien[0] && dr)        cause = CAUSE_RXDAT;
      else if (ien[1] && tx_pend_q) cause = CAUSE_TXMT;
      else if (ien[3] && msr_any)   cause = CAUSE_MODEM;
      else                          pend_any = 1'b0;
      iid    = '0;
      iid[0] = ~pend_any;
      iid[2:1] = cause;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         tx_pend_q <= 1'b0;
      end else begin
         if (thr_wr || (ien_wr && !ien_wbit))
            tx_pend_q <= 1'b0;
         else if ((ien[1] && thre_rise) || arm_en)
            tx_pend_q <= 1'b1;
         else if (iid_rd && pend_any && (cause == CAUSE_TXMT))
            tx_pend_q <= 1'b0;
      end
   end

   // R10
   tx_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tx_pend_q |-> thre);

   // R9
   line_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ien[2] && err_any) |-> (iid[2:1] == 2'b11 && !iid[0]));
endmodule

// File: rtl/uart_regbank.sv
module uart_regbank
   import uart_rb_pkg::*;
#(
   parameter int unsigned ADDR_W        = 3,
   parameter int unsigned BYTE_W        = 8,
   parameter int unsigned DIV_W         = 16,
   parameter logic [15:0] DIV_RESET     = 16'h000C,
   parameter bit          ARM_ON_ENABLE = 1'b1,
   parameter bit          RI_TRAIL_ONLY = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic              wr_en,
   input  logic              rd_en,
   input  logic [BYTE_W-1:0] wdata,
   output logic [BYTE_W-1:0] rdata,
   output logic [BYTE_W-1:0] tx_data,
   output logic              tx_valid,
   input  logic              tx_take,
   input  logic              tx_idle,
   input  logic              rx_valid,
   input  logic [BYTE_W-1:0] rx_data,
   input  logic              rx_parity_err,
   input  logic              rx_frame_err,
   input  logic              rx_break,
   input  logic              cts,
   input  logic              dsr,
   input  logic              ri,
   input  logic              rlsd,
   output logic              dtr,
   output logic              rts,
   output logic              out1,
   output logic              out2,
   output logic              loop_en,
   output logic [DIV_W-1:0]  divisor,
   output logic [1:0]        word_len,
   output logic              two_stop,
   output logic              parity_en,
   output logic              parity_even,
   output logic              parity_stick,
   output logic              send_break,
   output logic              irq
);
   localparam int unsigned N_CAUSE = 4;
   localparam int unsigned N_PINS  = 4;
   localparam int unsigned MCTL_W  = 5;
   localparam int unsigned DLAB_B  = BYTE_W - 1;

   generate
      if (ADDR_W != 3) begin : g_bad_addr
         $error("uart_regbank: ADDR_W must be 3");
      end
      if (BYTE_W != 8) begin : g_bad_byte
         $error("uart_regbank: BYTE_W must be 8");
      end
      if (DIV_W != 2 * BYTE_W) begin : g_bad_div
         $error("uart_regbank: DIV_W must be two bytes");
      end
   endgenerate

   logic [BYTE_W-1:0]  lctl_q;
   logic [MCTL_W-1:0]  mctl_q;
   logic [N_CAUSE-1:0] ien_q;
   logic [DIV_W-1:0]   div_q;
   logic [BYTE_W-1:0]  thr_q;
   logic               dlab;

   logic sel_data, sel_ien, sel_iid, sel_lctl, sel_mctl, sel_lsts, sel_msts;
   logic thr_wr, rbr_rd, lsr_rd, msr_rd, iid_rd, ien_wr;

   logic [BYTE_W-1:0] rbr, lsr, iid;
   logic              dr, err_any, thre, thre_rise, pend_any;
   logic [N_PINS-1:0] pins, delta;

   assign dlab     = lctl_q[DLAB_B];
   assign sel_data = (addr == ADDR_W'(OFS_DATA));
   assign sel_ien  = (addr == ADDR_W'(OFS_IEN));
   assign sel_iid  = (addr == ADDR_W'(OFS_IID));
   assign sel_lctl = (addr == ADDR_W'(OFS_LCTL));
   assign sel_mctl = (addr == ADDR_W'(OFS_MCTL));
   assign sel_lsts = (addr == ADDR_W'(OFS_LSTS));
   assign sel_msts = (addr == ADDR_W'(OFS_MSTS));

   assign thr_wr = wr_en & sel_data & ~dlab;
   assign ien_wr = wr_en & sel_ien & ~dlab;
   assign rbr_rd = rd_en & sel_data & ~dlab;
   assign lsr_rd = rd_en & sel_lsts;
   assign msr_rd = rd_en & sel_msts;
   assign iid_rd = rd_en & sel_iid;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         lctl_q <= '0;
         mctl_q <= '0;
         ien_q  <= '0;
         div_q  <= DIV_RESET;
         thr_q  <= '0;
      end else if (wr_en) begin
         if (sel_data && dlab)  div_q[BYTE_W-1:0]      <= wdata;
         if (sel_ien && dlab)   div_q[DIV_W-1:BYTE_W]  <= wdata;
         if (thr_wr)            thr_q  <= wdata;
         if (ien_wr)            ien_q  <= wdata[N_CAUSE-1:0];
         if (sel_lctl)          lctl_q <= wdata;
         if (sel_mctl)          mctl_q <= wdata[MCTL_W-1:0];
      end
   end

   assign pins = {rlsd, ri, dsr, cts};

   rb_line_status #(.BYTE_W(BYTE_W)) i_lsts (
      .clk       (clk),
      .rst_n     (rst_n),
      .rx_valid  (rx_valid),
      .rx_data   (rx_data),
      .rx_pe     (rx_parity_err),
      .rx_fe     (rx_frame_err),
      .rx_bi     (rx_break),
      .rbr_rd    (rbr_rd),
      .lsr_rd    (lsr_rd),
      .thr_wr    (thr_wr),
      .tx_take   (tx_take),
      .tx_idle   (tx_idle),
      .rbr       (rbr),
      .lsr       (lsr),
      .dr        (dr),
      .err_any   (err_any),
      .thre      (thre),
      .thre_rise (thre_rise)
   );

   rb_modem_delta #(
      .N_PINS        (N_PINS),
      .RI_IDX        (2),
      .RI_TRAIL_ONLY (RI_TRAIL_ONLY)
   ) i_mdelta (
      .clk    (clk),
      .rst_n  (rst_n),
      .pins   (pins),
      .rd_clr (msr_rd),
      .delta  (delta)
   );

   rb_irq_ctrl #(
      .BYTE_W        (BYTE_W),
      .N_CAUSE       (N_CAUSE),
      .ARM_ON_ENABLE (ARM_ON_ENABLE)
   ) i_irq (
      .clk       (clk),
      .rst_n     (rst_n),
      .ien       (ien_q),
      .ien_wr    (ien_wr),
      .ien_wbit  (wdata[1]),
      .err_any   (err_any),
      .dr        (dr),
      .thre      (thre),
      .thre_rise (thre_rise),
      .thr_wr    (thr_wr),
      .iid_rd    (iid_rd),
      .msr_any   (|delta),
      .iid       (iid),
      .pend_any  (pend_any)
   );

   always_comb begin
      rdata = '0;
      case (addr)
         ADDR_W'(OFS_DATA): rdata = dlab ? div_q[BYTE_W-1:0] : rbr;
         ADDR_W'(OFS_IEN):  rdata = dlab ? div_q[DIV_W-1:BYTE_W]
                                         : {{(BYTE_W-N_CAUSE){1'b0}}, ien_q};
         ADDR_W'(OFS_IID):  rdata = iid;
         ADDR_W'(OFS_LCTL): rdata = lctl_q;
         ADDR_W'(OFS_MCTL): rdata = {{(BYTE_W-MCTL_W){1'b0}}, mctl_q};
         ADDR_W'(OFS_LSTS): rdata = lsr;
         ADDR_W'(OFS_MSTS): rdata = {pins, delta};
         default:           rdata = '0;
      endcase
   end

   assign tx_data      = thr_q;
   assign tx_valid     = ~thre;
   assign dtr          = mctl_q[0];
   assign rts          = mctl_q[1];
   assign out1         = mctl_q[2];
   assign out2         = mctl_q[3];
   assign loop_en      = mctl_q[4];
   assign divisor      = div_q;
   assign word_len     = lctl_q[1:0];
   assign two_stop     = lctl_q[2];
   assign parity_en    = lctl_q[3];
   assign parity_even  = lctl_q[4];
   assign parity_stick = lctl_q[5];
   assign send_break   = lctl_q[6];
   assign irq          = out2 & pend_any;

   // R11
   irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (out2 && !rdata_iid_idle()));

   function automatic logic rdata_iid_idle();
      return iid[0];
   endfunction

   // R2
   div_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !dlab) |=> $stable(div_q));
endmodule

// File: tb/test_uart_regbank.sv
module test_uart_regbank;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [2:0] addr = '0;
   logic       wr_en = 1'b0, rd_en = 1'b0;
   logic [7:0] wdata = '0, rdata;
   logic [7:0] tx_data;
   logic       tx_valid, tx_take = 1'b0, tx_idle = 1'b1;
   logic       rx_valid = 1'b0;
   logic [7:0] rx_data = '0;
   logic       rx_pe = 1'b0, rx_fe = 1'b0, rx_bi = 1'b0;
   logic [3:0] pins = '0;
   logic       dtr, rts, out1, out2, loop_en;
   logic [15:0] divisor;
   logic [1:0] word_len;
   logic       two_stop, parity_en, parity_even, parity_stick, send_break, irq;

   int n_chk = 0, n_fail = 0;

   always #5 clk = ~clk;

   uart_regbank i_uart_regbank (
      .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
      .wdata(wdata), .rdata(rdata), .tx_data(tx_data), .tx_valid(tx_valid),
      .tx_take(tx_take), .tx_idle(tx_idle), .rx_valid(rx_valid),
      .rx_data(rx_data), .rx_parity_err(rx_pe), .rx_frame_err(rx_fe),
      .rx_break(rx_bi), .cts(pins[0]), .dsr(pins[1]), .ri(pins[2]),
      .rlsd(pins[3]), .dtr(dtr), .rts(rts), .out1(out1), .out2(out2),
      .loop_en(loop_en), .divisor(divisor), .word_len(word_len),
      .two_stop(two_stop), .parity_en(parity_en), .parity_even(parity_even),
      .parity_stick(parity_stick), .send_break(send_break), .irq(irq)
   );

   // bench model
   logic       m_dr, m_oe, m_pe, m_fe, m_bi, m_thre, m_pend;
   logic [7:0] m_rbr, m_ien;
   logic [3:0] m_delta;
   logic       m_out2;

   function automatic logic [7:0] exp_lsr();
      return {1'b0, tx_idle, m_thre, m_bi, m_fe, m_pe, m_oe, m_dr};
   endfunction

   function automatic logic [7:0] exp_iid();
      if (m_ien[2] && (m_oe | m_pe | m_fe | m_bi)) return 8'h06;
      if (m_ien[0] && m_dr)                       return 8'h04;
      if (m_ien[1] && m_pend)                     return 8'h02;
      if (m_ien[3] && (|m_delta))                 return 8'h00;
      return 8'h01;
   endfunction

   task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [7:0] d);
      @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
      @(negedge clk); wr_en = 1'b0;
   endtask

   task automatic rd(input logic [2:0] a, output logic [7:0] d);
      @(negedge clk); addr = a; rd_en = 1'b1;
      #1 d = rdata;
      @(negedge clk); rd_en = 1'b0;
   endtask

   task automatic rx(input logic [7:0] d, input logic pe, input logic fe, input logic bi);
      @(negedge clk); rx_valid = 1'b1; rx_data = d; rx_pe = pe; rx_fe = fe; rx_bi = bi;
      @(negedge clk); rx_valid = 1'b0; rx_pe = 1'b0; rx_fe = 1'b0; rx_bi = 1'b0;
      if (m_dr) m_oe = 1'b1;
      m_dr = 1'b1; m_rbr = d;
      m_pe |= pe; m_fe |= fe; m_bi |= bi;
   endtask

   task automatic take();
      @(negedge clk); tx_take = 1'b1;
      @(negedge clk); tx_take = 1'b0;
      if (!m_thre && m_ien[1]) m_pend = 1'b1;
      m_thre = 1'b1;
   endtask

   task automatic flip(input logic [3:0] m);
      @(negedge clk); pins = pins ^ m;
      @(negedge clk);
      m_delta |= m;
   endtask

   task automatic rd_lsr_chk(input string req);
      logic [7:0] v;
      rd(3'd5, v);
      chk(req, {8'h0, v}, {8'h0, exp_lsr()});
      m_oe = 0; m_pe = 0; m_fe = 0; m_bi = 0;
   endtask

   task automatic rd_iid_chk(input string req);
      logic [7:0] v, e;
      e = exp_iid();
      chk("R11 irq", {15'h0, irq}, {15'h0, m_out2 & ~e[0]});
      rd(3'd2, v);
      chk(req, {8'h0, v}, {8'h0, e});
      if (e == 8'h02) m_pend = 1'b0;
   endtask

   task automatic rd_msr_chk(input string req);
      logic [7:0] v;
      rd(3'd6, v);
      chk(req, {8'h0, v}, {8'h0, pins, m_delta});
      m_delta = '0;
   endtask

   task automatic rd_rbr_chk(input string req);
      logic [7:0] v;
      rd(3'd0, v);
      chk(req, {8'h0, v}, {8'h0, m_rbr});
      m_dr = 1'b0;
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      n_fail++; n_chk++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin : main
      logic [7:0] v;
      void'($urandom(32'd20240611));
      m_dr = 0; m_oe = 0; m_pe = 0; m_fe = 0; m_bi = 0; m_thre = 1; m_pend = 0;
      m_rbr = 0; m_ien = 0; m_delta = 0; m_out2 = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      // R1 reset state
      rd(3'd1, v); chk("R1 ien", {8'h0, v}, 16'h0000);
      rd(3'd3, v); chk("R1 lctl", {8'h0, v}, 16'h0000);
      rd(3'd4, v); chk("R1 mctl", {8'h0, v}, 16'h0000);
      rd(3'd5, v); chk("R1 lsts", {8'h0, v}, 16'h0060);
      rd(3'd2, v); chk("R1 iid", {8'h0, v}, 16'h0001);
      chk("R1 irq", {15'h0, irq}, 16'h0);

      // R3 line control fields
      wr(3'd3, 8'h3A);
      chk("R3 fields", {9'h0, send_break, parity_stick, parity_even, parity_en, two_stop, word_len},
          {9'h0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 2'b10});
      rd(3'd3, v); chk("R3 readback", {8'h0, v}, 16'h003A);
      wr(3'd3, 8'h47);
      chk("R3 fields2", {9'h0, send_break, parity_stick, parity_even, parity_en, two_stop, word_len},
          {9'h0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 2'b11});

      // R2 divisor access
      wr(3'd3, 8'h80);
      wr(3'd1, 8'h09);
      wr(3'd0, 8'h00);
      chk("R2 divisor", divisor, 16'h0900);
      rd(3'd1, v); chk("R2 div hi", {8'h0, v}, 16'h0009);
      rd(3'd0, v); chk("R2 div lo", {8'h0, v}, 16'h0000);
      wr(3'd3, 8'h03);
      wr(3'd1, 8'hF0);
      rd(3'd1, v); chk("R2 ien upper", {8'h0, v}, 16'h0000);
      chk("R2 divisor kept", divisor, 16'h0900);

      // R4 modem control
      wr(3'd4, 8'hFF);
      rd(3'd4, v); chk("R4 readback", {8'h0, v}, 16'h001F);
      chk("R4 pins", {11'h0, loop_en, out2, out1, rts, dtr}, 16'h001F);
      wr(3'd4, 8'h0A);
      chk("R4 pins2", {11'h0, loop_en, out2, out1, rts, dtr}, 16'h000A);
      m_out2 = 1'b1;

      // R10 arming on enable, R11 gating
      wr(3'd1, 8'h0F); m_ien = 8'h0F; m_pend = 1'b1;
      chk("R11 irq on", {15'h0, irq}, 16'h1);
      rd_iid_chk("R10 arm on enable");
      rd_iid_chk("R10 cleared by read");

      // R5 transmit path
      wr(3'd0, 8'h5A); m_thre = 1'b0; m_pend = 1'b0;
      chk("R5 tx_data", {8'h0, tx_data}, 16'h005A);
      chk("R5 tx_valid", {15'h0, tx_valid}, 16'h1);
      tx_idle = 1'b0;
      rd_lsr_chk("R5 lsts busy");
      take();
      tx_idle = 1'b1;
      rd_lsr_chk("R5 lsts after take");
      wr(3'd4, 8'h02); m_out2 = 1'b0;
      chk("R11 gated", {15'h0, irq}, 16'h0);
      rd_iid_chk("R10 rise arms");
      wr(3'd4, 8'h08); m_out2 = 1'b1;

      // R9 priority ordering, R6, R7, R8
      wr(3'd1, 8'h0D); m_ien = 8'h0D; m_pend = 1'b0;
      wr(3'd1, 8'h0F); m_ien = 8'h0F; m_pend = 1'b1;
      rx(8'hC3, 1'b1, 1'b0, 1'b0);
      flip(4'b0001);
      rd_iid_chk("R9 line first");
      rd_lsr_chk("R7 errors");
      rd_iid_chk("R9 data second");
      rx(8'h3C, 1'b0, 1'b1, 1'b1);
      rd_lsr_chk("R6 overrun");
      rd_lsr_chk("R7 cleared");
      rd_rbr_chk("R6 buffer");
      rd_lsr_chk("R6 ready cleared");
      rd_iid_chk("R9 txmt third");
      rd_iid_chk("R9 modem last");
      rd_msr_chk("R8 delta cts");
      rd_msr_chk("R8 delta cleared");
      flip(4'b1110);
      rd_msr_chk("R8 delta others");

      // random phase
      for (int it = 0; it < 400; it++) begin
         int op;
         op = $urandom % 7;
         case (op)
            0: rx(8'($urandom), ($urandom % 8) == 0, ($urandom % 8) == 0, ($urandom % 8) == 0);
            1: rd_rbr_chk("R6 rand buffer");
            2: rd_lsr_chk("R7 rand lsts");
            3: begin
               logic [3:0] m;
               m = 4'($urandom);
               flip(m);
               rd_msr_chk("R8 rand msts");
            end
            4: rd_iid_chk("R9 rand iid");
            5: begin
               wr(3'd0, 8'($urandom)); m_thre = 1'b0; m_pend = 1'b0;
               rd_lsr_chk("R5 rand busy");
               take();
            end
            default: begin
               logic [3:0] e;
               e = 4'($urandom);
               wr(3'd1, {4'h0, e});
               if (!e[1]) m_pend = 1'b0;
               else if (!m_ien[1] && m_thre) m_pend = 1'b1;
               m_ien = {4'h0, e};
               rd(3'd1, v); chk("R2 rand ien", {8'h0, v}, {12'h0, e});
            end
         endcase
      end

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule